// File: doc/BRIEF.md
# In-Order Retirement Controller

This block decides, every cycle, which of the oldest entries of a single-thread reorder buffer leave it. It looks at a window of `CW` head slots, oldest first, and walks them in order. Plain executed entries retire and count against the commit width. Squashed entries are dropped without counting. Walking stops at the first slot that is not eligible. Some slots can only be handled as the first commit of a cycle with the store path drained: unexecuted serialising instructions such as non-speculative operations, store-conditionals and barriers, and faulting instructions. An unexecuted serialising slot raises a request that carries its sequence number, so the execute side runs it. An unexecuted load raises the same request tagged as uncached.

A faulting slot does not retire. It moves the controller into a trap-pending state. A countdown loaded from a configuration input runs during that state, and no slot retires or raises a request. When the countdown expires, the controller emits a one-cycle request to squash the whole thread and goes back to normal operation.

The controller also tracks the committed program counter and the next program counter, which advance by a fixed instruction size per commit. It keeps a running count of the cycles in which the full commit width was used. The buffer storage itself and all architectural state updates are outside this block.

Top module: `retire_ctrl`

## Requirements
- R1: Slots are taken strictly oldest first (bit 0 of every per-slot port is the oldest). The walk stops at the first slot that is not valid or is neither ready nor squashed, so `retire_o` is always a contiguous run of ones starting at bit 0.
- R2: A valid squashed slot is retired whatever its ready flag says. It does not add to `commit_cnt_o`, and it does not count as an earlier commit for the first-slot rule of R3 and R6.
- R3: An unexecuted slot flagged non-speculative or barrier stops the walk without retiring and without a request if an earlier slot committed this cycle or `stores_pend` is high.
- R4: Otherwise, such a slot raises `req_vld_o` with `req_uncached_o` low and `req_seq_o` equal to its sequence number. It is not retired and the walk stops.
- R5: An unexecuted load slot (not non-speculative or barrier) raises `req_vld_o` with `req_uncached_o` high and its sequence number, whatever its position or `stores_pend`. It is not retired and the walk stops.
- R6: An executed faulting slot is not retired. If an earlier slot committed this cycle or stores are pending, the walk stops and nothing else happens. Otherwise `trap_pend_o` rises at the next clock edge.
- R7: With latency L sampled from `trap_lat` at trap entry, `squash_all_o` is high for exactly one cycle, starting L+1 edges after `trap_pend_o` rose. `trap_pend_o` falls on that same edge. While `trap_pend_o` is high, no slot retires and no request is raised.
- R8: `commit_cnt_o` gives the number of non-squashed slots retired in the current cycle. `full_cyc_o` increments at each edge where that count equals `CW`.
- R9: Each committed slot moves `pc_o` to the old `npc_o` and `npc_o` forward by `INST_BYTES`. After k commits in a cycle both have grown by k·`INST_BYTES`, and `npc_o` always equals `pc_o + INST_BYTES`.
- R10: After reset `pc_o` = `RESET_PC`, `npc_o` = `RESET_PC + INST_BYTES`, `full_cyc_o` = 0, and `trap_pend_o` and `squash_all_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_vld | input | CW | Slot holds an entry |
| hd_rdy | input | CW | Slot is ready to be considered for commit |
| hd_sq | input | CW | Slot entry was squashed |
| hd_exe | input | CW | Slot entry has executed |
| hd_nspec | input | CW | Non-speculative or store-conditional entry |
| hd_bar | input | CW | Memory or write barrier entry |
| hd_ld | input | CW | Load entry |
| hd_flt | input | CW | Entry carries a fault |
| hd_seq | input | CW*SEQ_W | Sequence numbers, slot i in bits [i*SEQ_W +: SEQ_W] |
| stores_pend | input | 1 | Stores still await writeback |
| trap_lat | input | LAT_W | Trap latency, sampled at trap entry |
| retire_o | output | CW | Slots removed from the buffer this cycle |
| commit_cnt_o | output | $clog2(CW+1) | Non-squashed slots committed this cycle |
| full_cyc_o | output | FC_W | Cycles that used the full commit width |
| req_vld_o | output | 1 | Execute request for the stopping slot |
| req_seq_o | output | SEQ_W | Sequence number of the requested slot |
| req_uncached_o | output | 1 | Request is an uncached load |
| trap_pend_o | output | 1 | Trap-pending state |
| squash_all_o | output | 1 | One-cycle whole-thread squash request |
| pc_o | output | PC_W | Committed program counter |
| npc_o | output | PC_W | Next program counter |

## Verification
The bench builds the block with a width of four slots, 8-bit sequence numbers and a 4-bit trap latency. With four slots, a single vector can place a commit, a squashed entry and a special entry at different positions, so the first-slot rule can be tested with earlier commits and with earlier squashed slots only. The small latency field allows the trap countdown to be followed edge by edge from 0 and from 3. The full-width counter is also reached in a few cycles.

// File: rtl/retire_pkg.sv
package retire_pkg;

    // Outcome of one head slot during the in-order walk
    typedef enum logic [2:0] {
        ACT_NONE,      // walk already stopped before this slot
        ACT_HALT,      // slot blocks; nothing retires from here on
        ACT_DROP,      // squashed slot removed, not counted
        ACT_COMMIT,    // slot retires and counts against the width
        ACT_NSPEC,     // serialising slot: send execute request
        ACT_UNCACHED,  // unexecuted load: send uncached request
        ACT_TRAP       // faulting slot: enter trap-pending
    } slot_act_e;

    function automatic logic act_passes(input slot_act_e a);
        return (a == ACT_DROP) || (a == ACT_COMMIT);
    endfunction

endpackage

// File: rtl/retire_scan.sv
module retire_scan
    import retire_pkg::*;
#(
    parameter int CW    = 4,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 3
) (
    input  logic                  en,
    input  logic [CW-1:0]         vld,
    input  logic [CW-1:0]         rdy,
    input  logic [CW-1:0]         sq,
    input  logic [CW-1:0]         exe,
    input  logic [CW-1:0]         nspec,
    input  logic [CW-1:0]         bar,
    input  logic [CW-1:0]         ld,
    input  logic [CW-1:0]         flt,
    input  logic [CW*SEQ_W-1:0]   seq,
    input  logic                  stores_pend,
    output logic [CW-1:0]         retire,
    output logic [CNT_W-1:0]      ncommit,
    output logic                  req_vld,
    output logic [SEQ_W-1:0]      req_seq,
    output logic                  req_unc,
    output logic                  trap_go
);

    logic [CW:0]      live;
    logic [CNT_W-1:0] done_n [CW+1];
    logic [CW-1:0]    ns_hit;
    logic [CW-1:0]    unc_hit;
    logic [CW-1:0]    trap_hit;

    assign live[0]   = en;
    assign done_n[0] = '0;

    for (genvar i = 0; i < CW; i++) begin : g_slot
        slot_act_e act;
        logic      first_ok;

        always_comb begin
            first_ok = (done_n[i] == '0) && !stores_pend;
            act      = ACT_NONE;
            if (live[i]) begin
                if (!(vld[i] && (rdy[i] || sq[i]))) begin
                    act = ACT_HALT;
                end else if (sq[i]) begin
                    act = ACT_DROP;
                end else if (!exe[i]) begin
                    if (nspec[i] || bar[i]) begin
                        act = first_ok ? ACT_NSPEC : ACT_HALT;
                    end else if (ld[i]) begin
                        act = ACT_UNCACHED;
                    end else begin
                        act = ACT_HALT;
                    end
                end else if (flt[i]) begin
                    act = first_ok ? ACT_TRAP : ACT_HALT;
                end else begin
                    act = ACT_COMMIT;
                end
            end
        end

        assign live[i+1]   = act_passes(act);
        assign done_n[i+1] = done_n[i] + CNT_W'(act == ACT_COMMIT);
        assign retire[i]   = act_passes(act);
        assign ns_hit[i]   = (act == ACT_NSPEC);
        assign unc_hit[i]  = (act == ACT_UNCACHED);
        assign trap_hit[i] = (act == ACT_TRAP);
    end

    always_comb begin
        req_seq = '0;
        for (int k = 0; k < CW; k++) begin
            if (ns_hit[k] || unc_hit[k]) begin
                req_seq = req_seq | seq[k*SEQ_W +: SEQ_W];
            end
        end
    end

    assign ncommit = done_n[CW];
    assign req_vld = |(ns_hit | unc_hit);
    assign req_unc = |unc_hit;
    assign trap_go = |trap_hit;

endmodule

// File: rtl/retire_trap_timer.sv
module retire_trap_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic [LAT_W-1:0] lat_cfg,
    output logic             trap_o,
    output logic             squash_o
);

    typedef struct packed {
        logic             trap;
        logic             squash;
        logic [LAT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.squash = 1'b0;
        if (st_q.trap) begin
            if (st_q.cnt == '0) begin
                st_d.trap   = 1'b0;
                st_d.squash = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (enter) begin
            st_d.trap = 1'b1;
            st_d.cnt  = lat_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_o   = st_q.trap;
    assign squash_o = st_q.squash;

    // R7: a squash pulse only ever follows a cycle in trap-pending
    assert_squash_after_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> $past(trap_o));

    // R7: the pulse is one cycle wide
    assert_squash_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> !squash_o);

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
    import retire_pkg::*;
#(
    parameter int          CW         = 4,
    parameter int          SEQ_W      = 16,
    parameter int          PC_W       = 32,
    parameter int          LAT_W      = 8,
    parameter int          FC_W       = 16,
    parameter int          INST_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             hd_vld,
    input  logic [CW-1:0]             hd_rdy,
    input  logic [CW-1:0]             hd_sq,
    input  logic [CW-1:0]             hd_exe,
    input  logic [CW-1:0]             hd_nspec,
    input  logic [CW-1:0]             hd_bar,
    input  logic [CW-1:0]             hd_ld,
    input  logic [CW-1:0]             hd_flt,
    input  logic [CW*SEQ_W-1:0]       hd_seq,
    input  logic                      stores_pend,
    input  logic [LAT_W-1:0]          trap_lat,
    output logic [CW-1:0]             retire_o,
    output logic [$clog2(CW+1)-1:0]   commit_cnt_o,
    output logic [FC_W-1:0]           full_cyc_o,
    output logic                      req_vld_o,
    output logic [SEQ_W-1:0]          req_seq_o,
    output logic                      req_uncached_o,
    output logic                      trap_pend_o,
    output logic                      squash_all_o,
    output logic [PC_W-1:0]           pc_o,
    output logic [PC_W-1:0]           npc_o
);

    localparam int CNT_W = $clog2(CW + 1);
    localparam logic [PC_W-1:0] STEP   = PC_W'(INST_BYTES);
    localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_PC);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] npc;
        logic [FC_W-1:0] full;
    } arch_t;

    arch_t st_d, st_q;

    logic [CNT_W-1:0] ncommit;
    logic             trap_go;
    logic             trap_q;
    logic             squash_q;

    retire_scan #(
        .CW    (CW),
        .SEQ_W (SEQ_W),
        .CNT_W (CNT_W)
    ) scan_i (
        .en          (!trap_q),
        .vld         (hd_vld),
        .rdy         (hd_rdy),
        .sq          (hd_sq),
        .exe         (hd_exe),
        .nspec       (hd_nspec),
        .bar         (hd_bar),
        .ld          (hd_ld),
        .flt         (hd_flt),
        .seq         (hd_seq),
        .stores_pend (stores_pend),
        .retire      (retire_o),
        .ncommit     (ncommit),
        .req_vld     (req_vld_o),
        .req_seq     (req_seq_o),
        .req_unc     (req_uncached_o),
        .trap_go     (trap_go)
    );

    retire_trap_timer #(
        .LAT_W (LAT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (trap_go),
        .lat_cfg  (trap_lat),
        .trap_o   (trap_q),
        .squash_o (squash_q)
    );

    always_comb begin
        logic [PC_W-1:0] adv;
        adv      = PC_W'(ncommit) * STEP;
        st_d     = st_q;
        st_d.pc  = st_q.pc + adv;
        st_d.npc = st_q.npc + adv;
        if (ncommit == CNT_W'(CW)) begin
            st_d.full = st_q.full + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= PC_RST;
            st_q.npc  <= PC_RST + STEP;
            st_q.full <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_cnt_o = ncommit;
    assign full_cyc_o   = st_q.full;
    assign pc_o         = st_q.pc;
    assign npc_o        = st_q.npc;
    assign trap_pend_o  = trap_q;
    assign squash_all_o = squash_q;

    // R1: retired slots form a run starting at the oldest slot
    assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((retire_o + 1'b1) & retire_o) == '0);

    // R8: committed count never exceeds the slots removed
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(retire_o) >= int'(commit_cnt_o));

    // R3: a non-uncached request only with the store path drained and no earlier commit
    assert_nspec_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_o && !req_uncached_o) |-> (!stores_pend && commit_cnt_o == '0));

    // R6: trap entry only from a cycle without pending stores
    assert_trap_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_pend_o) |-> $past(!stores_pend));

    // R7: nothing leaves the buffer and nothing is requested while trapped
    assert_trap_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pend_o |-> (retire_o == '0 && !req_vld_o));

    // R9: next PC keeps one instruction ahead of the committed PC
    assert_pc_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        npc_o == pc_o + STEP);

endmodule

// File: tb/retire_ctrl_tb_top.sv
`timescale 1ns/100ps
module retire_ctrl_tb_top;

    localparam int CW    = 4;
    localparam int SEQ_W = 8;
    localparam int LAT_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [CW-1:0]         hd_vld = '0, hd_rdy = '0, hd_sq = '0, hd_exe = '0;
    logic [CW-1:0]         hd_nspec = '0, hd_bar = '0, hd_ld = '0, hd_flt = '0;
    logic [CW*SEQ_W-1:0]   hd_seq = '0;
    logic                  stores_pend = 1'b0;
    logic [LAT_W-1:0]      trap_lat = '0;
    logic [CW-1:0]         retire_o;
    logic [2:0]            commit_cnt_o;
    logic [15:0]           full_cyc_o;
    logic                  req_vld_o, req_uncached_o, trap_pend_o, squash_all_o;
    logic [SEQ_W-1:0]      req_seq_o;
    logic [31:0]           pc_o, npc_o;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [CW-1:0]    ret;
        logic [2:0]       cnt;
        logic             rq;
        logic [SEQ_W-1:0] rs;
        logic             ru;
        string            tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    retire_ctrl #(
        .CW (CW), .SEQ_W (SEQ_W), .PC_W (32), .LAT_W (LAT_W), .FC_W (16),
        .INST_BYTES (4), .RESET_PC (32'h100)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .hd_vld (hd_vld), .hd_rdy (hd_rdy), .hd_sq (hd_sq), .hd_exe (hd_exe),
        .hd_nspec (hd_nspec), .hd_bar (hd_bar), .hd_ld (hd_ld), .hd_flt (hd_flt),
        .hd_seq (hd_seq), .stores_pend (stores_pend), .trap_lat (trap_lat),
        .retire_o (retire_o), .commit_cnt_o (commit_cnt_o), .full_cyc_o (full_cyc_o),
        .req_vld_o (req_vld_o), .req_seq_o (req_seq_o), .req_uncached_o (req_uncached_o),
        .trap_pend_o (trap_pend_o), .squash_all_o (squash_all_o),
        .pc_o (pc_o), .npc_o (npc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " retire"}, 32'(retire_o), 32'(e.ret));
                chk({e.tag, " count"}, 32'(commit_cnt_o), 32'(e.cnt));
                chk({e.tag, " req"}, 32'(req_vld_o), 32'(e.rq));
                if (e.rq) begin
                    chk({e.tag, " req_seq"}, 32'(req_seq_o), 32'(e.rs));
                    chk({e.tag, " uncached"}, 32'(req_uncached_o), 32'(e.ru));
                end
            end
        end
    end

    // Driver: called at a falling edge; applies one vector across one rising edge
    task automatic step(input logic [3:0] v, r, s, e, n, b, l, f,
                        input logic sp, input logic [7:0] base,
                        input logic [3:0] xr, input logic [2:0] xc,
                        input logic xq, input logic [7:0] xs, input logic xu,
                        input string tag);
        exp_t it;
        hd_vld = v; hd_rdy = r; hd_sq = s; hd_exe = e;
        hd_nspec = n; hd_bar = b; hd_ld = l; hd_flt = f;
        stores_pend = sp;
        hd_seq = {base + 8'd3, base + 8'd2, base + 8'd1, base};
        it.ret = xr; it.cnt = xc; it.rq = xq; it.rs = xs; it.ru = xu; it.tag = tag;
        sb.push_back(it);
        #2;
        @(negedge clk);
        hd_vld = '0; hd_rdy = '0; hd_sq = '0; hd_exe = '0;
        hd_nspec = '0; hd_bar = '0; hd_ld = '0; hd_flt = '0;
        stores_pend = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 trap", 32'(trap_pend_o), 0);
        chk("R10 squash", 32'(squash_all_o), 0);
        chk("R10 full", 32'(full_cyc_o), 0);
        chk("R10 pc", pc_o, 32'h100);
        chk("R9 npc reset", npc_o, 32'h104);

        // R8 full width commit
        step(4'hF, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0, 8'h10,
             4'hF, 3'd4, 0, 8'h0, 0, "R8 full");
        chk("R8 full_cyc", 32'(full_cyc_o), 1);
        chk("R9 pc after 4", pc_o, 32'h110);
        chk("R9 npc after 4", npc_o, 32'h114);

        // R1 stop at first not-ready slot
        step(4'hF, 4'hB, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0, 8'h14,
             4'h3, 3'd2, 0, 8'h0, 0, "R1 stop");
        chk("R8 full_cyc hold", 32'(full_cyc_o), 1);
        chk("R9 pc after 2", pc_o, 32'h118);

        // R2 squashed slot not ready still removed, not counted
        step(4'h3, 4'h2, 4'h1, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 0, 8'h18,
             4'h3, 3'd1, 0, 8'h0, 0, "R2 drop");
        chk("R2 pc", pc_o, 32'h11C);

        // R3 serialising slot after a commit waits
        step(4'h3, 4'h3, 4'h0, 4'h1, 4'h2, 4'h0, 4'h0, 4'h0, 0, 8'h1A,
             4'h1, 3'd1, 0, 8'h0, 0, "R3 after commit");
        chk("R3 pc", pc_o, 32'h120);

        // R3 serialising head with stores pending waits
        step(4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 1, 8'h1C,
             4'h0, 3'd0, 0, 8'h0, 0, "R3 stores pend");

        // R4 barrier behind a squashed slot raises request
        step(4'h3, 4'h2, 4'h1, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 0, 8'h20,
             4'h1, 3'd0, 1, 8'h21, 0, "R4 request");

        // R5 unexecuted load after two commits, stores pending
        step(4'h7, 4'h7, 4'h0, 4'h3, 4'h0, 4'h0, 4'h4, 4'h0, 1, 8'h30,
             4'h3, 3'd2, 1, 8'h32, 1, "R5 uncached");
        chk("R5 pc", pc_o, 32'h128);

        // R6 fault after a commit waits
        step(4'h3, 4'h3, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, 4'h2, 0, 8'h40,
             4'h1, 3'd1, 0, 8'h0, 0, "R6 fault wait");
        chk("R6 no trap", 32'(trap_pend_o), 0);

        // R6 fault head with stores pending waits
        step(4'h1, 4'h1, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 1, 8'h44,
             4'h0, 3'd0, 0, 8'h0, 0, "R6 fault stores");
        chk("R6 no trap stores", 32'(trap_pend_o), 0);

        // R6/R7 fault enters trap with latency 3
        trap_lat = 4'd3;
        step(4'h1, 4'h1, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 0, 8'h48,
             4'h0, 3'd0, 0, 8'h0, 0, "R6 fault");
        trap_lat = 4'd9;
        chk("R6 trap rise", 32'(trap_pend_o), 1);
        // R7 nothing retires or requests while trapped
        step(4'h3, 4'h3, 4'h0, 4'h2, 4'h0, 4'h0, 4'h1, 4'h0, 0, 8'h50,
             4'h0, 3'd0, 0, 8'h0, 0, "R7 blocked");
        chk("R7 trap e1", 32'(trap_pend_o), 1);
        @(negedge clk);
        chk("R7 sq e2", 32'(squash_all_o), 0);
        @(negedge clk);
        chk("R7 sq e3", 32'(squash_all_o), 0);
        chk("R7 trap e3", 32'(trap_pend_o), 1);
        @(negedge clk);
        chk("R7 sq e4", 32'(squash_all_o), 1);
        chk("R7 trap e4", 32'(trap_pend_o), 0);
        @(negedge clk);
        chk("R7 sq e5", 32'(squash_all_o), 0);
        chk("R7 pc held", pc_o, 32'h12C);

        // R9 commits resume
        step(4'h3, 4'h3, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 0, 8'h60,
             4'h3, 3'd2, 0, 8'h0, 0, "R9 resume");
        chk("R9 pc resume", pc_o, 32'h134);

        // R8 four removed but one squashed: not full width
        step(4'hF, 4'hF, 4'h1, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0, 8'h70,
             4'hF, 3'd3, 0, 8'h0, 0, "R8 squashed");
        chk("R8 full_cyc no inc", 32'(full_cyc_o), 1);
        step(4'hF, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1, 8'h74,
             4'hF, 3'd4, 0, 8'h0, 0, "R8 full again");
        chk("R8 full_cyc 2", 32'(full_cyc_o), 2);
        chk("R9 pc 7 more", pc_o, 32'h150);

        // R7 zero latency: squash on the very next edge
        trap_lat = 4'd0;
        step(4'h1, 4'h1, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 0, 8'h80,
             4'h0, 3'd0, 0, 8'h0, 0, "R7 lat0");
        chk("R7 lat0 trap", 32'(trap_pend_o), 1);
        @(negedge clk);
        chk("R7 lat0 squash", 32'(squash_all_o), 1);
        chk("R7 lat0 trap clr", 32'(trap_pend_o), 0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule